// File: doc/BRIEF.md
# Saturating Signed Adder-Subtractor

This block adds or subtracts two signed two's-complement operands in one combinational pass. The datapath is a chain of 4-bit carry look-ahead groups. Inside a group every carry comes from flattened two-level logic. Between groups the carry ripples to the next group up. One control input picks subtraction. It inverts the second operand bit by bit and also feeds the carry into the lowest group, so A + ~B + 1 is formed without any extra incrementer.

The result does not wrap on overflow. A true sign is rebuilt from the top operand bits and the final carry. If it disagrees with the sign of the raw sum, the output is forced to the nearest representable extreme and a flag is raised. The width must be a multiple of four. The intended sizes are 8 bits (two groups) and 12 bits (three groups).

Top module: `sat_cla_addsub`

## Requirements
- R1: With sub_i = 0 and the true sum A + B inside the signed range of WIDTH bits, sum_o equals A + B and ovf_o is 0. With both operands zero, sum_o is 0 and ovf_o is 0.
- R2: With sub_i = 1 and the true difference A − B inside the signed range, sum_o equals A − B and ovf_o is 0.
- R3: ovf_o is 1 exactly when the true result lies outside −2^(WIDTH−1) .. 2^(WIDTH−1)−1. This can only happen when the effective operand signs match (same signs for add, opposite signs for subtract).
- R4: When the true result exceeds the largest representable value, sum_o is 0 followed by all ones (0x7F for 8 bits, 0x7FF for 12 bits).
- R5: When the true result is below the smallest representable value, sum_o is 1 followed by all zeros (0x80 for 8 bits, 0x800 for 12 bits).
- R6: Carries cross group boundaries correctly in both sizes, for example 0x0F + 0x01 = 0x10 and 0x10 − 0x01 = 0x0F at 8 bits. A WIDTH that is not a multiple of four is rejected at elaboration.
- R7: Subtracting the most negative value saturates to the maximum when A ≥ 0. It gives the exact result without overflow when A < 0, for example −1 − (−128) = 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First signed operand |
| b_i | input | WIDTH | Second signed operand |
| sub_i | input | 1 | 1 selects A − B, 0 selects A + B |
| sum_o | output | WIDTH | Saturated signed result |
| ovf_o | output | 1 | High when the result was clamped |

## Verification
A broken generate or propagate term, or a bad flattened carry, shows up at once as a wrong sum_o. It only shows for operand pairs whose carry path passes through the faulty term, which is why the 8-bit size is swept exhaustively in both modes. A fault in the group-to-group carry or in the subtract carry-in moves the result by a power of sixteen or by one. That is visible on the first vector that exercises it. A fault in the rebuilt sign shows as a missing or spurious ovf_o, or as a clamp to the wrong extreme. The 12-bit size uses its corner values and random pairs to reach the third group.

// File: rtl/sat_cla_pkg.sv
package sat_cla_pkg;
  localparam int unsigned GRP_W = 4;

  typedef struct packed {
    logic [GRP_W-1:0] gen;
    logic [GRP_W-1:0] prp;
  } grp_gp_t;
endpackage

// File: rtl/sat_cla_group.sv
module sat_cla_group
  import sat_cla_pkg::*;
(
  input  logic [GRP_W-1:0] x_i,
  input  logic [GRP_W-1:0] y_i,
  input  logic             c_i,
  output logic [GRP_W-1:0] s_o,
  output logic             c_o
);
  grp_gp_t          gp;
  logic [GRP_W-1:0] cin;

  always_comb begin
    gp.gen = x_i & y_i;
    gp.prp = x_i | y_i;
  end

  // flattened two-level carries, no bit-to-bit ripple
  always_comb begin
    cin[0] = c_i;
    cin[1] = gp.gen[0] | (gp.prp[0] & c_i);
    cin[2] = gp.gen[1] | (gp.prp[1] & gp.gen[0])
           | (gp.prp[1] & gp.prp[0] & c_i);
    cin[3] = gp.gen[2] | (gp.prp[2] & gp.gen[1])
           | (gp.prp[2] & gp.prp[1] & gp.gen[0])
           | (gp.prp[2] & gp.prp[1] & gp.prp[0] & c_i);
    c_o    = gp.gen[3] | (gp.prp[3] & gp.gen[2])
           | (gp.prp[3] & gp.prp[2] & gp.gen[1])
           | (gp.prp[3] & gp.prp[2] & gp.prp[1] & gp.gen[0])
           | (gp.prp[3] & gp.prp[2] & gp.prp[1] & gp.prp[0] & c_i);
  end

  assign s_o = x_i ^ y_i ^ cin;
endmodule

// File: rtl/sat_cla_chain.sv
module sat_cla_chain
  import sat_cla_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] raw_o,
  output logic             bx_msb_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = WIDTH / GRP_W;

  logic [WIDTH-1:0] bx;
  logic [NGRP:0]    gc;

  assign bx    = b_i ^ {WIDTH{sub_i}};
  assign gc[0] = sub_i;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    sat_cla_group i_grp (
      .x_i (a_i[gi*GRP_W +: GRP_W]),
      .y_i (bx[gi*GRP_W +: GRP_W]),
      .c_i (gc[gi]),
      .s_o (raw_o[gi*GRP_W +: GRP_W]),
      .c_o (gc[gi+1])
    );
  end

  assign bx_msb_o = bx[WIDTH-1];
  assign cout_o   = gc[NGRP];
endmodule

// File: rtl/sat_cla_clamp.sv
module sat_cla_clamp #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             a_msb_i,
  input  logic             bx_msb_i,
  input  logic             cout_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

  logic true_sign;

  // sign of the (WIDTH+1)-bit exact result
  assign true_sign = a_msb_i ^ bx_msb_i ^ cout_i;
  assign ovf_o     = true_sign ^ raw_i[WIDTH-1];

  always_comb begin
    if (!ovf_o)        sum_o = raw_i;
    else if (true_sign) sum_o = NEG_LIM;
    else               sum_o = POS_LIM;
  end
endmodule

// File: rtl/sat_cla_addsub.sv
module sat_cla_addsub
  import sat_cla_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  if ((WIDTH % GRP_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("sat_cla_addsub: WIDTH must be a nonzero multiple of 4");
  end

  logic [WIDTH-1:0] raw;
  logic             bx_msb;
  logic             cout;

  sat_cla_chain #(.WIDTH(WIDTH)) i_chain (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (sub_i),
    .raw_o    (raw),
    .bx_msb_o (bx_msb),
    .cout_o   (cout)
  );

  sat_cla_clamp #(.WIDTH(WIDTH)) i_clamp (
    .raw_i    (raw),
    .a_msb_i  (a_i[WIDTH-1]),
    .bx_msb_i (bx_msb),
    .cout_i   (cout),
    .sum_o    (sum_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/sat_cla_checker.sv
module sat_cla_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             ovf_o
);
  localparam logic [WIDTH-1:0] POS_LIM = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIM = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] wrapped;
  assign wrapped = sub_i ? (a_i - b_i) : (a_i + b_i);

  always_comb begin
    // R1 / R2: without overflow the result is the plain wrapped arithmetic
    a_r1_r2_exact: assert (ovf_o || sum_o == wrapped);
    // R3: overflow needs effective operand signs that match
    a_r3_sign_cond: assert (!ovf_o || ((a_i[WIDTH-1] ^ b_i[WIDTH-1]) == sub_i));
    // R3: overflow means the wrapped sign left the operand sign
    a_r3_wrap_flip: assert (!ovf_o || (wrapped[WIDTH-1] != a_i[WIDTH-1]));
    // R4
    a_r4_pos_clamp: assert (!(ovf_o && !a_i[WIDTH-1]) || sum_o == POS_LIM);
    // R5
    a_r5_neg_clamp: assert (!(ovf_o && a_i[WIDTH-1]) || sum_o == NEG_LIM);
  end
endmodule

bind sat_cla_addsub sat_cla_checker #(.WIDTH(WIDTH)) i_sat_cla_checker (
  .a_i   (a_i),
  .b_i   (b_i),
  .sub_i (sub_i),
  .sum_o (sum_o),
  .ovf_o (ovf_o)
);

// File: tb/test_sat_cla_addsub.sv
module test_sat_cla_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  a8, b8, s8;
  logic        sub8, o8;
  logic [11:0] a12, b12, s12;
  logic        sub12, o12;

  sat_cla_addsub #(.WIDTH(8)) i_sat_cla_addsub (
    .a_i(a8), .b_i(b8), .sub_i(sub8), .sum_o(s8), .ovf_o(o8)
  );
  sat_cla_addsub #(.WIDTH(12)) i_sat_cla_addsub_w12 (
    .a_i(a12), .b_i(b12), .sub_i(sub12), .sum_o(s12), .ovf_o(o12)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {a, b, sub, expected sum, expected ovf}
  localparam int NVEC = 12;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h05, 8'h03, 1'b0, 8'h08, 1'b0},  // R1
    {8'h7F, 8'h01, 1'b0, 8'h7F, 1'b1},  // R4
    {8'h80, 8'hFF, 1'b0, 8'h80, 1'b1},  // R5
    {8'h0F, 8'h01, 1'b0, 8'h10, 1'b0},  // R6
    {8'h10, 8'h01, 1'b1, 8'h0F, 1'b0},  // R6 / R2
    {8'h80, 8'h01, 1'b1, 8'h80, 1'b1},  // R5
    {8'h00, 8'h80, 1'b1, 8'h7F, 1'b1},  // R7
    {8'hFF, 8'h80, 1'b1, 8'h7F, 1'b0},  // R7
    {8'h64, 8'h64, 1'b0, 8'h7F, 1'b1},  // R4
    {8'hC0, 8'hC0, 1'b0, 8'h80, 1'b0},  // R3 boundary
    {8'h7F, 8'hFF, 1'b1, 8'h7F, 1'b1},  // R4
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b0}   // R1
  };

  function automatic longint sx(longint v, int w);
    return (v >= (64'sd1 <<< (w-1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  // returns {ovf, sum}
  function automatic longint ref_calc(longint a, longint b, bit sub, int w);
    longint r, mx, mn;
    bit     ov;
    mx = (64'sd1 <<< (w-1)) - 1;
    mn = -(64'sd1 <<< (w-1));
    r  = sub ? sx(a, w) - sx(b, w) : sx(a, w) + sx(b, w);
    ov = (r > mx) || (r < mn);
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return (longint'(ov) <<< w) | (r & ((64'sd1 <<< w) - 1));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string req_of(longint e, bit sub, int w);
    if (e >>> w) return ((e >>> (w-1)) & 1) ? "R5/R3" : "R4/R3";
    return sub ? "R2" : "R1";
  endfunction

  task automatic run8(logic [7:0] a, logic [7:0] b, bit sub);
    longint e;
    @(posedge clk); #1;
    a8 = a; b8 = b; sub8 = sub;
    @(negedge clk);
    e = ref_calc(a, b, sub, 8);
    chk(req_of(e, sub, 8), {o8, s8}, e);
  endtask

  task automatic run12(logic [11:0] a, logic [11:0] b, bit sub);
    longint e;
    @(posedge clk); #1;
    a12 = a; b12 = b; sub12 = sub;
    @(negedge clk);
    e = ref_calc(a, b, sub, 12);
    chk(req_of(e, sub, 12), {o12, s12}, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [11:0] corner [5];
    corner = '{12'h7FF, 12'h800, 12'h000, 12'hFFF, 12'h001};
    a8 = '0; b8 = '0; sub8 = 1'b0;
    a12 = '0; b12 = '0; sub12 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle state, zero operands
    chk("R1 reset", {o8, s8}, 9'h000);
    chk("R1 reset w12", {o12, s12}, 13'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      {a8, b8, sub8} = VEC[i][25:9];
      @(negedge clk);
      chk($sformatf("R%0s vec%0d", (VEC[i][8:1] == 8'h7F && VEC[i][0]) ? "4" :
          (VEC[i][8:1] == 8'h80 && VEC[i][0]) ? "5" : "6/R7", i),
          {o8, s8}, {VEC[i][0], VEC[i][8:1]});
    end

    // R1..R7 exhaustive at 8 bits
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run8(8'(a), 8'(b), s[0]);

    // R6 / R7 at 12 bits: corners then random pairs
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run12(corner[i], corner[j], s[0]);
    run12(12'h00F, 12'h001, 1'b0);  // R6 group carry into group 1
    run12(12'h0FF, 12'h001, 1'b0);  // R6 into group 2
    run12(12'h100, 12'h001, 1'b1);  // R6 borrow across groups
    for (int k = 0; k < 2000; k++)
      run12(12'($urandom), 12'($urandom), 1'($urandom));

    finish_run();
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule